// File: doc/BRIEF.md
# Token-seeded handshake FIFO

This block is a single-clock first-in first-out buffer with a valid/ready handshake on both sides. Unlike an ordinary FIFO, it does not come out of reset empty. A synchronous reset loads it with a parameterised number of starting words whose values are also parameters. This lets it sit on the return arc of a dataflow loop and supply the tokens that the loop needs before its first result comes back.

The producer side offers `in_data` with `in_valid` and sees `in_ready`. The consumer side sees `out_data` with `out_valid` and answers with `out_ready`. Both `in_ready` and `out_valid` come straight from flops. Neither one depends combinationally on `in_valid` or `out_ready`, so the buffer can close a loop without creating a combinational cycle.

Top module: `seeded_fifo`

## Requirements
- R1: In the cycle after a synchronous reset, the occupancy equals INIT_COUNT, `out_valid` is high exactly when INIT_COUNT > 0, and `in_ready` is high exactly when INIT_COUNT < DEPTH.
- R2: Starting word k (for k < INIT_COUNT) is bits [k*DATA_W +: DATA_W] of INIT_WORDS. The starting words leave in increasing k, word 0 first, and come ahead of any word pushed later.
- R3: DEPTH is a power of two and the address width is log2(DEPTH). The occupancy never exceeds DEPTH, and `in_ready` is low whenever DEPTH words are held.
- R4: A word is stored only in a cycle where `in_valid` and `in_ready` are both high. With `in_valid` low, nothing is stored, whatever `in_data` carries.
- R5: `out_valid` is high exactly when the buffer is non-empty. A word is removed only when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` stays unchanged.
- R6: A push and a pop in the same cycle leave the occupancy unchanged. When the buffer is full, an offered word is refused in that cycle even if a pop also happens.
- R7: Words leave in the order they were accepted.
- R8: `in_ready` and `out_valid` do not change within a cycle when `in_valid` or `out_ready` change.
- R9: Asserting reset in the middle of traffic discards the contents and restores the R1/R2 starting state at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the starting words |
| in_data | input | DATA_W | Producer data |
| in_valid | input | 1 | Producer data is valid |
| in_ready | output | 1 | Buffer can accept a word this cycle |
| out_data | output | DATA_W | Word at the head of the buffer |
| out_valid | output | 1 | Head word is valid |
| out_ready | input | 1 | Consumer takes the head word this cycle |

## Verification
On every cycle, the assertions check the following:
- the occupancy bound, and that the buffer refuses input when full;
- that `out_valid` follows the occupancy;
- that the head word holds while the consumer stalls;
- that balanced push/pop cycles and idle cycles leave the occupancy alone.

Only the bench scenarios can show the rest:
- the actual order and values of the words, including the starting words;
- that a full buffer refuses a word even while popping;
- that reset in mid-traffic restores the starting state;
- that the handshake outputs ignore same-cycle input changes.

// File: rtl/seeded_fifo.sv
module seeded_fifo #(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 8,
  parameter int INIT_COUNT = 3,
  parameter logic [DEPTH*DATA_W-1:0] INIT_WORDS = 64'h0000_0000_00C3_B2A1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] INIT_WR  = AW'(INIT_COUNT % DEPTH);
  localparam logic [CW-1:0] INIT_CNT = CW'(INIT_COUNT);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     count, count_nxt;
  logic              full_q, empty_q;
  logic              push, pop;

  assign in_ready  = ~full_q;
  assign out_valid = ~empty_q;
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid & ~full_q;
  assign pop       = out_ready & ~empty_q;

  always_comb begin
    case ({push, pop})
      2'b10:   count_nxt = count + 1'b1;
      2'b01:   count_nxt = count - 1'b1;
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < INIT_COUNT) ? INIT_WORDS[i*DATA_W +: DATA_W] : '0;
      rd_ptr  <= '0;
      wr_ptr  <= INIT_WR;
      count   <= INIT_CNT;
      full_q  <= (INIT_COUNT == DEPTH);
      empty_q <= (INIT_COUNT == 0);
    end else begin
      if (push) begin
        mem[wr_ptr] <= in_data;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count   <= count_nxt;
      full_q  <= (count_nxt == FULL_CNT);
      empty_q <= (count_nxt == '0);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  a_r3_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (count == FULL_CNT) |-> !in_ready);
  a_r5_valid_tracks: assert property (@(posedge clk) disable iff (rst)
    out_valid == (count != '0));
  a_r5_head_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r6_balanced: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_valid && out_ready) |=> (count == $past(count)));
  a_r4_idle: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !(out_valid && out_ready)) |=> ($stable(count) && $stable(wr_ptr)));
endmodule

// File: tb/sim_seeded_fifo.sv
`timescale 1ns/1ps
module sim_seeded_fifo;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int NINIT  = 3;
  localparam logic [DEPTH*DATA_W-1:0] WORDS = 64'h0000_0000_00C3_B2A1;

  logic clk = 0, rst = 1;
  logic [DATA_W-1:0] in_data = '0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [DATA_W-1:0] out_data;
  int checks = 0, errors = 0;
  logic [DATA_W-1:0] q [$];

  always #2.5 clk = ~clk;

  seeded_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .INIT_COUNT(NINIT), .INIT_WORDS(WORDS)) u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready));

  function automatic logic [DATA_W-1:0] init_word(int k);
    return WORDS[k*DATA_W +: DATA_W];
  endfunction

  function automatic logic exp_ready(int n);
    return n < DEPTH;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, "/R5 out_valid"}, 32'(out_valid), 32'(q.size() != 0));
    chk({tag, "/R3 in_ready"}, 32'(in_ready), 32'(exp_ready(q.size())));
    if (q.size() != 0) chk({tag, "/R7 out_data"}, 32'(out_data), 32'(q[0]));
  endtask

  task automatic cycle(logic v, logic [DATA_W-1:0] d, logic r, string tag);
    logic push, pop;
    in_valid = v; in_data = d; out_ready = r;
    push = v && exp_ready(q.size());
    pop  = r && (q.size() != 0);
    @(negedge clk);
    if (pop) void'(q.pop_front());
    if (push) q.push_back(d);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; out_ready = 0;
    @(negedge clk);
    rst = 0;
    q.delete();
    for (int k = 0; k < NINIT; k++) q.push_back(init_word(k));
    chk("R1 out_valid", 32'(out_valid), 32'(NINIT > 0));
    chk("R1 in_ready", 32'(in_ready), 32'(NINIT < DEPTH));
    compare("R1");
  endtask

  task automatic comb_probe();
    logic rv, vv;
    rv = in_ready; vv = out_valid;
    in_valid = ~in_valid; out_ready = ~out_ready;
    #0.5;
    chk("R8 in_ready", 32'(in_ready), 32'(rv));
    chk("R8 out_valid", 32'(out_valid), 32'(vv));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    do_reset();
    comb_probe();
    for (int k = 0; k < NINIT; k++) begin
      chk("R2 preload order", 32'(out_data), 32'(init_word(k)));
      cycle(0, 8'h00, 1, "R2");
    end
    chk("R2 drained", 32'(out_valid), 32'(0));
    for (int k = 0; k < 4; k++) cycle(0, 8'(8'h5A + k), 0, "R4");
    chk("R4 ignored while invalid", 32'(out_valid), 32'(0));
    for (int k = 0; k < DEPTH + 2; k++) cycle(1, 8'(8'h10 + k), 0, "R3");
    chk("R3 full refuses", 32'(in_ready), 32'(0));
    comb_probe();
    cycle(1, 8'hEE, 1, "R6");
    chk("R6 full pop no push", 32'(q.size()), 32'(DEPTH - 1));
    chk("R6 in_ready after", 32'(in_ready), 32'(1));
    cycle(1, 8'h77, 1, "R6");
    chk("R6 balanced keeps count", 32'(in_ready), 32'(1));
    for (int k = 0; k < 2000; k++) begin
      if (k == 1000) begin
        do_reset();
        chk("R9 restored head", 32'(out_data), 32'(init_word(0)));
      end
      cycle(1'($urandom_range(0, 99) < 60), 8'($urandom), 1'($urandom_range(0, 99) < 50), "R7");
      if (k % 250 == 0) comb_probe();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule